// File: doc/BRIEF.md
# I2C Address-Phase Status Flag Tracker

This block watches an I2C bus that is oversampled by a fast system clock and keeps three status flags for the address byte that follows every start condition. The flags are: an extension-code flag, an own-address-match flag and a transmit/receive direction flag. It also produces a permission bit that tells the surrounding bus engine when it may drive SDA. The block works in both master and slave roles. It does not shift later data bytes, generate SCL, drive ACK or arbitrate. The engine around it reports arbitration loss, communication release and wait release as single-cycle pulses.

SCL and SDA pass through a synchronizer of configurable depth. Start is SDA falling while SCL is high, and stop is SDA rising while SCL is high. A bit counter follows the rising SCL edges of the first byte only. The flags are set at fixed points in that byte: the eighth rising edge sets the address flags, and the ninth falling edge grants SDA permission. A list of bus and control events clears them. When a clear and a set fall in the same cycle, the clear wins.

Top module: `addr_phase_tracker`

## Requirements
- R1: After reset, `ext_code`, `addr_match`, `xmit` and `sda_oe_allow` are all 0.
- R2: On the eighth rising SCL edge after a start, `ext_code` sets if the first four bits received (bus order, most significant bit first) are all 0 or all 1. Otherwise it stays 0.
- R3: On that same edge, `addr_match` sets if the first seven bits received equal `own_addr`, with the first bit on the bus compared to `own_addr[6]`.
- R4: `ext_code` and `addr_match` clear on a start, a stop, a `comm_release` pulse, and whenever `enable` is 0.
- R5: In slave role (`role_master`=0), a start clears `xmit`. On the eighth rising edge, `xmit` takes the value of the eighth bit received: 1 means transmit.
- R6: In master role, a start sets `xmit` to 1. On the eighth rising edge, `xmit` becomes the inverse of `master_rw`, the direction bit the master drives.
- R7: `xmit` and `sda_oe_allow` clear on a stop, a `comm_release` pulse, an `arb_lost` pulse, and whenever `enable` is 0. `arb_lost` leaves `ext_code` and `addr_match` unchanged.
- R8: `sda_oe_allow` becomes 1 only on the falling SCL edge of the first byte's ninth clock, and only while `xmit` is 1. It is never 1 while `xmit` is 0.
- R9: A `wait_release` pulse clears `xmit` and `sda_oe_allow` if it arrives while `xmit` is 1 and the bus is in the ninth-clock window. That window runs from the ninth rising edge of the first byte to the next rising SCL edge. Outside the window the pulse has no effect.
- R10: When a clear event and a set event fall in the same cycle, the clear wins.
- R11: Bytes after the first one in a transfer do not change any flag.
- R12: An SCL edge at the pins affects the outputs on the third rising clock edge after the pin change, with the default two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level from the pad |
| sda_in | input | 1 | SDA line level from the pad |
| enable | input | 1 | Block enable; 0 holds the tracker and flags cleared |
| comm_release | input | 1 | Pulse: leave the current transfer |
| wait_release | input | 1 | Pulse: end the ninth-clock wait |
| arb_lost | input | 1 | Pulse: arbitration was lost |
| role_master | input | 1 | 1 = master role, 0 = slave role |
| master_rw | input | 1 | Direction bit the master drives as bit eight of the first byte |
| own_addr | input | ADDR_W | Own slave address |
| ext_code | output | 1 | Extension code received |
| addr_match | output | 1 | Received address equals own address |
| xmit | output | 1 | 1 = transmit status, 0 = receive status |
| sda_oe_allow | output | 1 | SDA may be driven by the transmit path |

## Verification
The bench builds the block with its defaults: a 7-bit address and two synchronizer stages. With these settings every possible first byte (all 256 values) can be sent in slave role, and the expected flags are computed arithmetically from each byte. The own address alternates between the byte's own upper seven bits and a fixed other value, so both a match and a miss are seen across the whole space. The fixed synchronizer depth also lets the bench place control pulses in the exact cycle in which an eighth-edge set would land. This checks both the latency and the clear-over-set priority.

// File: rtl/apt_pkg.sv
`timescale 1ns/1ps
package apt_pkg;

   // Bus events decoded from the synchronized lines, one cycle wide each.
   typedef struct packed {
      logic start;
      logic stop;
      logic scl_rise;
      logic scl_fall;
   } bus_evt_t;

   localparam int EXT_NIBBLE_W = 4;

   // An extension code is a leading nibble of all zeros or all ones.
   function automatic logic nibble_is_ext(input logic [EXT_NIBBLE_W-1:0] hi);
      return (hi == '0) || (hi == '1);
   endfunction

endpackage

// File: rtl/apt_sync.sv
`timescale 1ns/1ps
module apt_sync #(
   parameter int                WIDTH   = 2,
   parameter int                STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   for (genvar i = 0; i < STAGES; i++) begin : g_stg
      logic [WIDTH-1:0] r;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= g_stg[i-1].r;
         end
      end
   end

   assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/apt_bus_events.sv
`timescale 1ns/1ps
module apt_bus_events
   import apt_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_s,
   input  logic     sda_s,
   output bus_evt_t evt
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_comb begin
      evt.scl_rise = scl_s & ~scl_q;
      evt.scl_fall = ~scl_s & scl_q;
      evt.start    = scl_s & scl_q & sda_q & ~sda_s;
      evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
   end

endmodule

// File: rtl/apt_frame.sv
`timescale 1ns/1ps
module apt_frame
   import apt_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  bus_evt_t          evt,
   input  logic              sda_s,
   output logic              eighth,
   output logic              ninth_fall,
   output logic              in_ninth,
   output logic [ADDR_W-1:0] rx_addr,
   output logic              rx_lsb
);

   // ADDR_W address bits, one direction bit, one acknowledge bit.
   localparam int LAST  = ADDR_W + 2;
   localparam int CNT_W = $clog2(LAST + 1);
   localparam logic [CNT_W-1:0] CNT_DIR  = CNT_W'(ADDR_W);
   localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(ADDR_W + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAST);

   logic [CNT_W-1:0]  cnt;
   logic              first;
   logic [ADDR_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         first    <= 1'b0;
         in_ninth <= 1'b0;
         shreg    <= '0;
      end else if (!enable) begin
         cnt      <= '0;
         first    <= 1'b0;
         in_ninth <= 1'b0;
      end else if (evt.start) begin
         cnt      <= '0;
         first    <= 1'b1;
         in_ninth <= 1'b0;
      end else if (evt.stop) begin
         first    <= 1'b0;
         in_ninth <= 1'b0;
      end else begin
         if (evt.scl_rise) begin
            in_ninth <= first && (cnt == CNT_ACK);
            if (first) cnt <= cnt + 1'b1;
            if (first && (cnt < CNT_DIR)) shreg <= {shreg[ADDR_W-2:0], sda_s};
         end
         if (evt.scl_fall && first && (cnt == CNT_LAST)) first <= 1'b0;
      end
   end

   assign eighth     = enable & evt.scl_rise & first & (cnt == CNT_DIR);
   assign ninth_fall = enable & evt.scl_fall & first & (cnt == CNT_LAST);
   assign rx_addr    = shreg;
   assign rx_lsb     = sda_s;

endmodule

// File: rtl/apt_flags.sv
`timescale 1ns/1ps
module apt_flags
   import apt_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              comm_release,
   input  logic              wait_release,
   input  logic              arb_lost,
   input  logic              role_master,
   input  logic              master_rw,
   input  logic              ev_start,
   input  logic              ev_stop,
   input  logic              eighth,
   input  logic              ninth_fall,
   input  logic              in_ninth,
   input  logic [ADDR_W-1:0] rx_addr,
   input  logic              rx_lsb,
   input  logic [ADDR_W-1:0] own_addr,
   output logic              ext_code,
   output logic              addr_match,
   output logic              xmit,
   output logic              sda_oe_allow
);

   logic ext_hit, match_hit, wait_hit;
   logic clr_addr, clr_dir, clr_oe;

   assign ext_hit   = nibble_is_ext(rx_addr[ADDR_W-1 -: EXT_NIBBLE_W]);
   assign match_hit = (rx_addr == own_addr);
   assign wait_hit  = wait_release & in_ninth & xmit;

   // Clear sources; each one outranks any set in the same cycle.
   assign clr_addr = ~enable | comm_release | ev_start | ev_stop;
   assign clr_dir  = ~enable | comm_release | ev_stop | arb_lost | wait_hit
                   | (ev_start & ~role_master);
   assign clr_oe   = clr_dir | ev_start | eighth;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_code   <= 1'b0;
         addr_match <= 1'b0;
      end else if (clr_addr) begin
         ext_code   <= 1'b0;
         addr_match <= 1'b0;
      end else if (eighth) begin
         if (ext_hit)   ext_code   <= 1'b1;
         if (match_hit) addr_match <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      xmit <= 1'b0;
      else if (clr_dir)                xmit <= 1'b0;
      else if (ev_start & role_master) xmit <= 1'b1;
      else if (eighth)                 xmit <= role_master ? ~master_rw : rx_lsb;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 sda_oe_allow <= 1'b0;
      else if (clr_oe)            sda_oe_allow <= 1'b0;
      else if (ninth_fall & xmit) sda_oe_allow <= 1'b1;
   end

endmodule

// File: rtl/addr_phase_tracker.sv
`timescale 1ns/1ps
module addr_phase_tracker
   import apt_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic              enable,
   input  logic              comm_release,
   input  logic              wait_release,
   input  logic              arb_lost,
   input  logic              role_master,
   input  logic              master_rw,
   input  logic [ADDR_W-1:0] own_addr,
   output logic              ext_code,
   output logic              addr_match,
   output logic              xmit,
   output logic              sda_oe_allow
);

   if (ADDR_W < EXT_NIBBLE_W + 1) begin : g_bad_addr_w
      $error("addr_phase_tracker: ADDR_W must be at least 5");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("addr_phase_tracker: SYNC_STAGES must be at least 2");
   end

   logic [1:0]        bus_s;
   bus_evt_t          evt;
   logic              ev_start, ev_stop;
   logic              eighth, ninth_fall, in_ninth;
   logic [ADDR_W-1:0] rx_addr;
   logic              rx_lsb;

   apt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_in, sda_in}),
      .q     (bus_s)
   );

   apt_bus_events u_events (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_s (bus_s[1]),
      .sda_s (bus_s[0]),
      .evt   (evt)
   );

   assign ev_start = enable & evt.start;
   assign ev_stop  = enable & evt.stop;

   apt_frame #(.ADDR_W(ADDR_W)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .evt        (evt),
      .sda_s      (bus_s[0]),
      .eighth     (eighth),
      .ninth_fall (ninth_fall),
      .in_ninth   (in_ninth),
      .rx_addr    (rx_addr),
      .rx_lsb     (rx_lsb)
   );

   apt_flags #(.ADDR_W(ADDR_W)) u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .comm_release (comm_release),
      .wait_release (wait_release),
      .arb_lost     (arb_lost),
      .role_master  (role_master),
      .master_rw    (master_rw),
      .ev_start     (ev_start),
      .ev_stop      (ev_stop),
      .eighth       (eighth),
      .ninth_fall   (ninth_fall),
      .in_ninth     (in_ninth),
      .rx_addr      (rx_addr),
      .rx_lsb       (rx_lsb),
      .own_addr     (own_addr),
      .ext_code     (ext_code),
      .addr_match   (addr_match),
      .xmit         (xmit),
      .sda_oe_allow (sda_oe_allow)
   );

endmodule

// File: rtl/apt_checker.sv
`timescale 1ns/1ps
module apt_checker (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic comm_release,
   input logic wait_release,
   input logic arb_lost,
   input logic role_master,
   input logic ev_start,
   input logic ev_stop,
   input logic eighth,
   input logic ninth_fall,
   input logic in_ninth,
   input logic ext_code,
   input logic addr_match,
   input logic xmit,
   input logic sda_oe_allow
);

   assert_ext_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_code) |-> $past(eighth))
      else $error("ext_code rose outside the eighth edge");

   assert_match_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_match) |-> $past(eighth))
      else $error("addr_match rose outside the eighth edge");

   assert_addr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_start || ev_stop || comm_release || !enable) |=> (!ext_code && !addr_match))
      else $error("address flags survived a clear event");

   assert_slave_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_start && !role_master) |=> !xmit)
      else $error("slave start left xmit set");

   assert_master_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_start && role_master && enable && !comm_release && !arb_lost && !wait_release)
         |=> xmit)
      else $error("master start did not set xmit");

   assert_dir_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stop || comm_release || arb_lost || !enable) |=> (!xmit && !sda_oe_allow))
      else $error("direction flag survived a clear event");

   assert_oe_needs_xmit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe_allow |-> xmit)
      else $error("SDA permission while receiving");

   assert_oe_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_allow) |-> $past(ninth_fall))
      else $error("SDA permission granted outside the ninth falling edge");

   assert_wait_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_release && in_ninth && xmit) |=> (!xmit && !sda_oe_allow))
      else $error("wait release in the ninth window did not clear xmit");

   assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (eighth && comm_release) |=> (!ext_code && !addr_match && !xmit))
      else $error("a set beat a clear in the same cycle");

endmodule

bind addr_phase_tracker apt_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .enable       (enable),
   .comm_release (comm_release),
   .wait_release (wait_release),
   .arb_lost     (arb_lost),
   .role_master  (role_master),
   .ev_start     (ev_start),
   .ev_stop      (ev_stop),
   .eighth       (eighth),
   .ninth_fall   (ninth_fall),
   .in_ninth     (in_ninth),
   .ext_code     (ext_code),
   .addr_match   (addr_match),
   .xmit         (xmit),
   .sda_oe_allow (sda_oe_allow)
);

// File: tb/addr_phase_tracker_tb.sv
`timescale 1ns/1ps
module addr_phase_tracker_tb;

   localparam int H = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1, sda = 1'b1;
   logic       enable = 1'b1;
   logic       comm_release = 1'b0, wait_release = 1'b0, arb_lost = 1'b0;
   logic       role_master = 1'b0, master_rw = 1'b0;
   logic [6:0] own_addr = 7'h00;
   logic       ext_code, addr_match, xmit, sda_oe_allow;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   addr_phase_tracker u_dut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .enable(enable),
      .comm_release(comm_release), .wait_release(wait_release), .arb_lost(arb_lost),
      .role_master(role_master), .master_rw(master_rw), .own_addr(own_addr),
      .ext_code(ext_code), .addr_match(addr_match), .xmit(xmit),
      .sda_oe_allow(sda_oe_allow)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic bus_start();
      sda = 1'b1; cyc(H); scl = 1'b1; cyc(H); sda = 1'b0; cyc(H); scl = 1'b0; cyc(H);
   endtask

   task automatic bus_stop();
      scl = 1'b0; sda = 1'b0; cyc(H); scl = 1'b1; cyc(H); sda = 1'b1; cyc(H);
   endtask

   task automatic clock_bit(input logic v);
      sda = v; cyc(H); scl = 1'b1; cyc(H); scl = 1'b0; cyc(H);
   endtask

   // Sends the first byte and leaves SCL high after the eighth rising edge.
   task automatic send_addr(input logic [7:0] by);
      for (int i = 7; i >= 1; i--) clock_bit(by[i]);
      sda = by[0]; cyc(H); scl = 1'b1; cyc(H);
   endtask

   task automatic ninth_rise();
      scl = 1'b0; cyc(H); sda = 1'b1; cyc(H); scl = 1'b1; cyc(H);
   endtask

   task automatic ninth_low();
      scl = 1'b0; cyc(H);
   endtask

   task automatic addr_full(input logic [7:0] by);
      bus_start(); send_addr(by); ninth_rise(); ninth_low();
   endtask

   task automatic pulse(ref logic sig);
      sig = 1'b1; cyc(1); sig = 1'b0; cyc(1);
   endtask

   initial begin
      cyc(3);
      chk("R1 reset ext_code", ext_code, 1'b0);
      chk("R1 reset addr_match", addr_match, 1'b0);
      chk("R1 reset xmit", xmit, 1'b0);
      chk("R1 reset sda_oe_allow", sda_oe_allow, 1'b0);
      rst_n = 1'b1; cyc(H);

      // Slave sweep over every first byte.
      for (int b = 0; b < 256; b++) begin
         logic [7:0] by;
         logic e_ext, e_match;
         by = 8'(b);
         own_addr = by[0] ? by[7:1] : 7'h55;
         e_ext   = (by[7:4] == 4'h0) || (by[7:4] == 4'hF);
         e_match = (by[7:1] == own_addr);
         bus_start();
         send_addr(by);
         chk("R2 sweep ext_code", ext_code, e_ext);
         chk("R3 sweep addr_match", addr_match, e_match);
         chk("R5 sweep xmit", xmit, by[0]);
         ninth_rise();
         chk("R8 sweep oe before ninth fall", sda_oe_allow, 1'b0);
         ninth_low();
         chk("R8 sweep oe after ninth fall", sda_oe_allow, by[0]);
         bus_stop();
         chk("R4 stop clears ext_code", ext_code, 1'b0);
         chk("R4 stop clears addr_match", addr_match, 1'b0);
         chk("R7 stop clears xmit", xmit, 1'b0);
      end

      // Master role.
      role_master = 1'b1;
      for (int k = 0; k < 16; k++) begin
         logic [7:0] by;
         by = 8'(k * 37 + 3);
         master_rw = by[0];
         bus_start();
         chk("R6 master start sets xmit", xmit, 1'b1);
         send_addr(by);
         chk("R6 master direction", xmit, ~by[0]);
         ninth_rise(); ninth_low();
         chk("R8 master oe", sda_oe_allow, ~by[0]);
         bus_stop();
      end
      role_master = 1'b0;
      own_addr = 7'h78;

      // Release pulse clears everything.
      addr_full(8'hF1);
      chk("R2 setup ext_code", ext_code, 1'b1);
      chk("R8 setup oe", sda_oe_allow, 1'b1);
      pulse(comm_release);
      chk("R4 release clears ext_code", ext_code, 1'b0);
      chk("R4 release clears addr_match", addr_match, 1'b0);
      chk("R7 release clears xmit", xmit, 1'b0);
      chk("R7 release clears oe", sda_oe_allow, 1'b0);
      bus_stop();

      // Arbitration loss clears only direction.
      addr_full(8'hF1);
      pulse(arb_lost);
      chk("R7 arb clears xmit", xmit, 1'b0);
      chk("R7 arb clears oe", sda_oe_allow, 1'b0);
      chk("R7 arb keeps ext_code", ext_code, 1'b1);
      chk("R7 arb keeps addr_match", addr_match, 1'b1);
      bus_stop();

      // Wait release outside and inside the ninth window.
      bus_start(); send_addr(8'hF1);
      pulse(wait_release);
      chk("R9 wait outside window ignored", xmit, 1'b1);
      ninth_rise(); ninth_low();
      chk("R9 oe granted", sda_oe_allow, 1'b1);
      pulse(wait_release);
      chk("R9 wait clears xmit", xmit, 1'b0);
      chk("R9 wait clears oe", sda_oe_allow, 1'b0);
      chk("R9 wait keeps ext_code", ext_code, 1'b1);
      bus_stop();

      // Enable low.
      addr_full(8'hF1);
      enable = 1'b0; cyc(2);
      chk("R4 disable clears ext_code", ext_code, 1'b0);
      chk("R4 disable clears addr_match", addr_match, 1'b0);
      chk("R7 disable clears xmit", xmit, 1'b0);
      chk("R7 disable clears oe", sda_oe_allow, 1'b0);
      enable = 1'b1; cyc(H);
      bus_stop();

      // Repeated start in slave role.
      addr_full(8'hF1);
      bus_start();
      chk("R4 restart clears ext_code", ext_code, 1'b0);
      chk("R4 restart clears addr_match", addr_match, 1'b0);
      chk("R5 restart clears xmit", xmit, 1'b0);
      chk("R8 restart clears oe", sda_oe_allow, 1'b0);
      bus_stop();

      // Second byte leaves flags alone.
      addr_full(8'hF1);
      for (int i = 7; i >= 0; i--) clock_bit(1'b0);
      ninth_rise(); ninth_low();
      chk("R11 second byte ext_code", ext_code, 1'b1);
      chk("R11 second byte addr_match", addr_match, 1'b1);
      chk("R11 second byte xmit", xmit, 1'b1);
      bus_stop();

      // Latency of the eighth-edge set.
      bus_start();
      for (int i = 7; i >= 1; i--) clock_bit(1'b1);
      sda = 1'b1; cyc(H); scl = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R12 not yet set after two edges", ext_code, 1'b0);
      @(posedge clk); @(negedge clk);
      chk("R12 set on third edge", ext_code, 1'b1);
      cyc(H); ninth_rise(); ninth_low(); bus_stop();

      // Clear in the same cycle as the eighth-edge set.
      bus_start();
      for (int i = 7; i >= 1; i--) clock_bit(1'b1);
      sda = 1'b1; cyc(H); scl = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      comm_release = 1'b1;
      @(posedge clk); @(negedge clk);
      comm_release = 1'b0;
      cyc(H);
      chk("R10 clear wins ext_code", ext_code, 1'b0);
      chk("R10 clear wins xmit", xmit, 1'b0);
      ninth_rise(); ninth_low(); bus_stop();

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog (R1..) actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule